// File: doc/BRIEF.md
# Interrupt Redirection Entry Dispatcher

This block keeps one 64-bit routing entry per interrupt input pin and turns pin events into delivery requests for a shared delivery path downstream. Software programs each entry through a simple word-wide register port. When a pin strobes, its event is held as pending until the dispatcher services it. At that point the entry is read and split into the fields a delivery request needs: vector, delivery mode, destination mode, trigger mode and destination. If the entry's mask bit is set, the event is dropped.

Delivery modes and both destination modes pass through unchanged, because the logic that resolves destinations downstream also filters the modes. When an entry is level-triggered, the dispatcher sets a remote-pending status bit in that entry at the moment it issues the request. An end-of-interrupt notice that carries the same vector clears the bit again.

The request leaves the block on a valid/ready stream. A request stays on the output, with every field unchanged, until the consumer takes it with `req_ready`. While the output is stalled, further pin events wait as pending, one event per pin. Events on several pins are served from the lowest pin number upward, one for each accepted transfer.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: After reset, `req_valid` is 0, every entry's low word reads 0x0001_0000 (masked, all other fields zero), every high word reads 0, and no remote-pending bit is set.
- R2: `reg_addr` selects entry `reg_addr[ADDR_W-1:1]`, and `reg_addr[0]` picks the high (1) or low (0) 32-bit word. A write with `reg_wr_en` stores the word at the next clock edge. `reg_rdata` shows the addressed word combinationally. Writes to entry numbers at or above NUM_PINS are ignored, and reads of those numbers return 0.
- R3: Bit 14 of the low word is the remote-pending bit. A register write never changes it, and it reads back only its tracked value.
- R4: For an unmasked entry, a `pin_fire` bit seen at a clock edge while the output is free loads a request at that same edge. The request carries `req_vector` = low[7:0], `req_delmode` = low[10:8] and `req_dest` = high[31:24].
- R5: Low bit 11 is the destination mode. When it is 0, `req_phys` is 1 (physical). When it is 1, `req_phys` is 0 (logical). All eight delivery-mode values pass through without filtering.
- R6: The mask bit (low bit 16) is checked when an event is serviced. If it is set, the event is discarded, no request is produced, and the pin's pending event is cleared, so unmasking afterwards produces nothing.
- R7: When several pins have events pending, the lowest pin number is served first, one pin per loaded request. A second strobe on a pin that is already pending merges into the one pending event.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and every request field stays stable.
- R9: When low bit 15 is 1 (level), the entry's remote-pending bit becomes 1 at the edge that loads the request, and `req_level` is 1. When bit 15 is 0 (edge), remote-pending is left as it is and `req_level` is 0.
- R10: `eoi_valid` with `eoi_vector` clears remote-pending in every level-triggered entry whose vector matches. Edge-triggered entries and entries with other vectors are untouched. If a set and a clear hit the same entry at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (6) | {entry number, high-word select} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_fire | input | NUM_PINS (24) | One-cycle event strobe per pin |
| eoi_valid | input | 1 | End-of-interrupt notice |
| eoi_vector | input | 8 | Vector being retired |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Consumer accepts request |
| req_vector | output | 8 | Interrupt vector |
| req_delmode | output | 3 | Delivery mode, unfiltered |
| req_phys | output | 1 | 1 = physical destination, 0 = logical |
| req_level | output | 1 | 1 = level-triggered |
| req_dest | output | 8 | Destination field |

## Verification
The bench builds the block at its default of 24 pins. With 24 pins, a 5-bit entry number has spare codes 24 to 31, so out-of-range writes and reads can be tested, and pin 23 tests the top boundary of the table. The bench holds `req_ready` low to stack events on three pins at once and to repeat a strobe on a pin that is already pending. This shows the lowest-first order, the merging of repeated strobes, and stable fields under back-pressure. It also programs two level entries that share a vector, next to an edge entry with that vector and a level entry with a different vector, so the end-of-interrupt match can be checked in every direction.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int VEC_W       = 8;
  localparam int DMODE_LSB   = 8;
  localparam int DMODE_W     = 3;
  localparam int DSTMODE_BIT = 11;
  localparam int RP_BIT      = 14;
  localparam int TRIG_BIT    = 15;
  localparam int MASK_BIT    = 16;
  localparam int DEST_SHIFT  = 24;
  localparam int DEST_W      = 8;

  localparam logic [31:0] LO_RESET = 32'h1 << MASK_BIT;
  localparam logic [31:0] RP_MASK  = 32'h1 << RP_BIT;

  typedef struct packed {
    logic [VEC_W-1:0]   vector;
    logic [DMODE_W-1:0] delmode;
    logic               logical;
    logic               level;
    logic [DEST_W-1:0]  dest;
  } irq_req_t;

  function automatic irq_req_t unpack_entry(input logic [31:0] lo, input logic [31:0] hi);
    irq_req_t r;
    r.vector  = lo[VEC_W-1:0];
    r.delmode = lo[DMODE_LSB +: DMODE_W];
    r.logical = lo[DSTMODE_BIT];
    r.level   = lo[TRIG_BIT];
    r.dest    = hi[DEST_SHIFT +: DEST_W];
    return r;
  endfunction
endpackage

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_dispatch_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_hi,
  output logic [31:0]      rdata,
  input  logic [IDX_W-1:0] svc_idx,
  output logic [31:0]      svc_lo,
  output logic [31:0]      svc_hi,
  input  logic             rp_set,
  input  logic [IDX_W-1:0] rp_set_idx,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic [N-1:0]     mask_vec,
  output logic [N-1:0]     rp_vec
);
  logic [31:0] lo_q [N];
  logic [31:0] hi_q [N];
  logic [N-1:0] rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= '0;
      end
      rp_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (wr_en && int'(wr_idx) == i) begin
          if (wr_hi) hi_q[i] <= wdata;
          else       lo_q[i] <= wdata & ~RP_MASK;
        end
        if (rp_set && int'(rp_set_idx) == i)
          rp_q[i] <= 1'b1;
        else if (eoi_valid && lo_q[i][TRIG_BIT] && lo_q[i][VEC_W-1:0] == eoi_vector)
          rp_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata  = '0;
    svc_lo = '0;
    svc_hi = '0;
    for (int i = 0; i < N; i++) begin
      mask_vec[i] = lo_q[i][MASK_BIT];
      if (int'(rd_idx) == i)
        rdata = rd_hi ? hi_q[i] : (lo_q[i] | ({31'b0, rp_q[i]} << RP_BIT));
      if (int'(svc_idx) == i) begin
        svc_lo = lo_q[i];
        svc_hi = hi_q[i];
      end
    end
  end

  assign rp_vec = rp_q;
endmodule

// File: rtl/irq_pin_arbiter.sv
module irq_pin_arbiter #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     fire,
  input  logic [N-1:0]     mask_vec,
  input  logic             take,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx,
  output logic [N-1:0]     pend_vec
);
  logic [N-1:0] pend_q, live, pend_d;

  always_comb begin
    live        = (pend_q | fire) & ~mask_vec;
    grant_valid = |live;
    grant_idx   = '0;
    for (int i = N - 1; i >= 0; i--)
      if (live[i]) grant_idx = IDX_W'(i);
    pend_d = live;
    if (take && grant_valid)
      pend_d = live & ~(N'(1) << grant_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_vec = pend_q;
endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage
  import irq_dispatch_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  irq_req_t in_req,
  input  logic     req_ready,
  output logic     can_load,
  output logic     req_valid,
  output irq_req_t out_req
);
  logic     valid_q;
  irq_req_t req_q;

  assign can_load = !valid_q || req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end else if (can_load) begin
      valid_q <= load;
      if (load) req_q <= in_req;
    end
  end

  assign req_valid = valid_q;
  assign out_req   = req_q;
endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W   = $clog2(NUM_PINS),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_fire,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [7:0]          req_vector,
  output logic [2:0]          req_delmode,
  output logic                req_phys,
  output logic                req_level,
  output logic [7:0]          req_dest
);
  logic [IDX_W-1:0]    reg_idx;
  logic                reg_in_range;
  logic [NUM_PINS-1:0] mask_vec, rp_vec, pend_vec;
  logic                grant_valid, can_load, svc_load;
  logic [IDX_W-1:0]    svc_idx;
  logic [31:0]         svc_lo, svc_hi, table_rdata;
  irq_req_t            svc_req, out_req;
  logic                svc_level;

  assign reg_idx      = reg_addr[ADDR_W-1:1];
  assign reg_in_range = int'(reg_idx) < NUM_PINS;
  assign reg_rdata    = reg_in_range ? table_rdata : 32'h0;

  irq_entry_table #(.N(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en && reg_in_range),
    .wr_idx     (reg_idx),
    .wr_hi      (reg_addr[0]),
    .wdata      (reg_wdata),
    .rd_idx     (reg_idx),
    .rd_hi      (reg_addr[0]),
    .rdata      (table_rdata),
    .svc_idx    (svc_idx),
    .svc_lo     (svc_lo),
    .svc_hi     (svc_hi),
    .rp_set     (svc_load && svc_level),
    .rp_set_idx (svc_idx),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .mask_vec   (mask_vec),
    .rp_vec     (rp_vec)
  );

  irq_pin_arbiter #(.N(NUM_PINS), .IDX_W(IDX_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (pin_fire),
    .mask_vec    (mask_vec),
    .take        (can_load),
    .grant_valid (grant_valid),
    .grant_idx   (svc_idx),
    .pend_vec    (pend_vec)
  );

  assign svc_req   = unpack_entry(svc_lo, svc_hi);
  assign svc_level = svc_req.level;
  assign svc_load  = grant_valid && can_load;

  irq_req_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (svc_load),
    .in_req    (svc_req),
    .req_ready (req_ready),
    .can_load  (can_load),
    .req_valid (req_valid),
    .out_req   (out_req)
  );

  assign req_vector  = out_req.vector;
  assign req_delmode = out_req.delmode;
  assign req_phys    = !out_req.logical;
  assign req_level   = out_req.level;
  assign req_dest    = out_req.dest;
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker #(
  parameter int N     = 24,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [7:0]       req_vector,
  input logic [7:0]       req_dest,
  input logic [2:0]       req_delmode,
  input logic             req_phys,
  input logic             req_level,
  input logic             svc_load,
  input logic             svc_level,
  input logic [IDX_W-1:0] svc_idx,
  input logic [N-1:0]     mask_vec,
  input logic [N-1:0]     rp_vec,
  input logic             eoi_valid
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable({req_vector, req_dest, req_delmode, req_phys, req_level})); // R8

  AST_NO_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_load |-> !mask_vec[svc_idx]); // R6

  AST_LOAD_SHOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    svc_load |=> req_valid); // R4

  AST_LEVEL_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    svc_load && svc_level |=> rp_vec[$past(svc_idx)]); // R9

  AST_EOI_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !svc_load |=> $countones(rp_vec) <= $past($countones(rp_vec))); // R10

  AST_LEVEL_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    svc_load |=> req_level == $past(svc_level)); // R9
endmodule

bind irq_redirect_dispatch irq_dispatch_checker #(.N(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vector  (req_vector),
  .req_dest    (req_dest),
  .req_delmode (req_delmode),
  .req_phys    (req_phys),
  .req_level   (req_level),
  .svc_load    (svc_load),
  .svc_level   (svc_level),
  .svc_idx     (svc_idx),
  .mask_vec    (mask_vec),
  .rp_vec      (rp_vec),
  .eoi_valid   (eoi_valid)
);

// File: tb/irq_redirect_dispatch_test.sv
module irq_redirect_dispatch_test;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pin_fire = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        req_valid, req_ready, req_phys, req_level;
  logic [7:0]  req_vector, req_dest;
  logic [2:0]  req_delmode;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_redirect_dispatch #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_fire(pin_fire),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .req_valid(req_valid),
    .req_ready(req_ready), .req_vector(req_vector), .req_delmode(req_delmode),
    .req_phys(req_phys), .req_level(req_level), .req_dest(req_dest)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int pin, input bit hi, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = {5'(pin), hi}; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int pin, input bit hi, output logic [31:0] d);
    reg_addr = {5'(pin), hi};
    #1 d = reg_rdata;
  endtask

  // drive one strobe cycle; returns at the negedge after the loading edge
  task automatic fire(input logic [NP-1:0] m);
    @(negedge clk); pin_fire = m;
    @(negedge clk); pin_fire = '0;
  endtask

  task automatic chk_req(input string tag, input logic [7:0] v, input logic [7:0] d,
                         input logic [2:0] dm, input logic ph, input logic lv);
    chk({tag, " valid"}, {31'b0, req_valid}, 32'd1);
    chk({tag, " vector"}, {24'b0, req_vector}, {24'b0, v});
    chk({tag, " dest"}, {24'b0, req_dest}, {24'b0, d});
    chk({tag, " delmode"}, {29'b0, req_delmode}, {29'b0, dm});
    chk({tag, " phys"}, {31'b0, req_phys}, {31'b0, ph});
    chk({tag, " level"}, {31'b0, req_level}, {31'b0, lv});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 req_valid", {31'b0, req_valid}, 32'd0);
    rd(0, 0, d);  chk("R1 pin0 low", d, 32'h0001_0000);
    rd(23, 0, d); chk("R1 pin23 low", d, 32'h0001_0000);
    rd(23, 1, d); chk("R1 pin23 high", d, 32'h0);
  endtask

  task automatic t_regport;
    logic [31:0] d;
    wr(5, 0, 32'h0000_CA31);
    wr(5, 1, 32'h1234_5678);
    rd(5, 0, d); chk("R3 write of bit14 ignored", d, 32'h0000_8A31);
    rd(5, 1, d); chk("R2 high word", d, 32'h1234_5678);
    wr(30, 0, 32'hDEAD_BEEF);
    rd(30, 0, d); chk("R2 out of range read", d, 32'h0);
    rd(23, 0, d); chk("R2 neighbour untouched", d, 32'h0001_0000);
  endtask

  task automatic t_basic;
    wr(2, 0, 32'h0000_0041);
    wr(2, 1, 32'h0300_0000);
    req_ready = 1'b1;
    fire(NP'(1) << 2);
    chk_req("R4 basic", 8'h41, 8'h03, 3'd0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R4 single request", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_modes;
    wr(4, 0, 32'h0000_0F77);
    wr(4, 1, 32'hFF00_0000);
    fire(NP'(1) << 4);
    chk_req("R5 logical mode7", 8'h77, 8'hFF, 3'd7, 1'b0, 1'b0);
    wr(23, 0, 32'h0000_05E0);
    wr(23, 1, 32'h8000_0000);
    fire(NP'(1) << 23);
    chk_req("R5 pin23 physical mode5", 8'hE0, 8'h80, 3'd5, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_mask;
    wr(6, 0, 32'h0001_0050);
    fire(NP'(1) << 6);
    chk("R6 masked no request", {31'b0, req_valid}, 32'd0);
    @(negedge clk);
    chk("R6 masked still none", {31'b0, req_valid}, 32'd0);
    wr(6, 0, 32'h0000_0050);
    @(negedge clk);
    chk("R6 unmask produces nothing", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_arb;
    wr(1, 0, 32'h0000_0061);
    wr(3, 0, 32'h0000_0063);
    wr(5, 0, 32'h0000_0065);
    @(negedge clk); req_ready = 1'b0;
    fire((NP'(1) << 1) | (NP'(1) << 3) | (NP'(1) << 5));
    chk("R7 lowest first", {24'b0, req_vector}, 32'h61);
    fire(NP'(1) << 3);
    chk("R8 held under stall", {24'b0, req_vector}, 32'h61);
    chk("R8 valid held", {31'b0, req_valid}, 32'd1);
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk);
    chk("R7 second pin3", {24'b0, req_vector}, 32'h63);
    @(negedge clk);
    chk("R7 third pin5", {24'b0, req_vector}, 32'h65);
    @(negedge clk);
    chk("R7 repeated strobe merged", {31'b0, req_valid}, 32'd0);
  endtask

  task automatic t_level_eoi;
    logic [31:0] d;
    wr(8, 0, 32'h0000_8092);
    wr(9, 0, 32'h0000_8092);
    wr(10, 0, 32'h0000_0092);
    wr(11, 0, 32'h0000_8093);
    fire(NP'(1) << 8);
    chk("R9 level flag", {31'b0, req_level}, 32'd1);
    rd(8, 0, d); chk("R9 pending at load edge", d, 32'h0000_C092);
    fire((NP'(1) << 9) | (NP'(1) << 10) | (NP'(1) << 11));
    repeat (3) @(negedge clk);
    rd(9, 0, d);  chk("R9 pin9 pending", d, 32'h0000_C092);
    rd(10, 0, d); chk("R9 edge leaves pending", d, 32'h0000_0092);
    rd(11, 0, d); chk("R9 pin11 pending", d, 32'h0000_C093);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = 8'h92;
    @(negedge clk); eoi_valid = 1'b0;
    rd(8, 0, d);  chk("R10 pin8 cleared", d, 32'h0000_8092);
    rd(9, 0, d);  chk("R10 pin9 cleared", d, 32'h0000_8092);
    rd(11, 0, d); chk("R10 other vector kept", d, 32'h0000_C093);
    @(negedge clk); pin_fire = NP'(1) << 8; eoi_valid = 1'b1; eoi_vector = 8'h92;
    @(negedge clk); pin_fire = '0; eoi_valid = 1'b0;
    rd(8, 0, d);  chk("R10 set wins over clear", d, 32'h0000_C092);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regport;
    t_basic;
    t_modes;
    t_mask;
    t_arb;
    t_level_eoi;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule